// File: doc/BRIEF.md
# Quadrature Position Counter with Wrap Flags

This block keeps a position count for an incremental encoder. In quadrature mode it uses four-way evaluation: every legal change of the A/B pair moves the count by one step, up or down. In up/down mode each rising edge of A is one count step, and B sets the direction of that step. A direction-invert bit swaps up and down in both modes. A gate input with selectable polarity can hold the count frozen. A synchronous zero request from the neighbouring reset logic clears the count.

Two flags report that the count has wrapped. The overflow flag shows a wrap from the top of the range to zero. The underflow flag shows a wrap from zero to the top. Each flag clears by hysteresis once the count has moved far enough back into the range. A read does not clear them. While either counter-reset source is enabled, wrap tracking is switched off and both flags stay low.

The decoder is a state machine over the last A/B phase, with states PH_00, PH_01, PH_10 and PH_11. Each clock it moves to the phase now on the inputs. The legal transitions are:

- Forward: PH_00→PH_10, PH_10→PH_11, PH_11→PH_01 and PH_01→PH_00.
- Reverse: the same four transitions taken the other way.
- Illegal: PH_00↔PH_11 and PH_10↔PH_01. These are double changes.

The flag machine has three states: FL_CLEAR, FL_OVER and FL_UNDER. Its transitions are:

- wrap-up goes to FL_OVER.
- wrap-down goes to FL_UNDER.
- FL_OVER→FL_CLEAR happens when the new count passes one third of the range.
- FL_UNDER→FL_CLEAR happens when the new count drops below two thirds of the range.
- tracking-off sends any state to FL_CLEAR.

Top module: `qenc_position_counter`

## Requirements
- R1: After reset, `count` is 0 and both `ovf_flag` and `unf_flag` are low.
- R2: With `mode_updown`=0, the input pair {A,B} moves through 00→10→11→01→00 in the forward direction. Each forward change adds 1 to `count` at the next clock edge, and each change in the reverse order subtracts 1.
- R3: In quadrature mode, a change of both A and B in one clock (00↔11 or 10↔01) leaves `count` unchanged.
- R4: With `mode_updown`=1, each rising edge of A changes `count` by one step. The count goes up if B is 0 and down if B is 1. Falling edges of A and changes of B alone leave `count` unchanged.
- R5: With `dir_invert`=1, every step goes the opposite way from R2 and R4.
- R6: When `gate_in` equals `gate_pol`, the counter is blocked and `count` does not step. With `gate_pol`=1 a high gate blocks, and with `gate_pol`=0 a low gate blocks. The decoder phase still tracks the inputs while blocked.
- R7: `zero_req` sets `count` to 0 at the next clock edge. This wins over a count step in the same cycle.
- R8: A step up from all-ones to zero sets `ovf_flag` at the same edge.
- R9: `ovf_flag` clears at the edge where `count` becomes greater than floor(2^CNT_W/3). It stays set while `count` is at or below that value.
- R10: A step down from zero to all-ones sets `unf_flag` at the same edge.
- R11: `unf_flag` clears at the edge where `count` becomes less than floor(2^(CNT_W+1)/3). It stays set while `count` is at or above that value.
- R12: While `idx_reset_en` or `ext_reset_en` is high, wraps set no flag, and any flag already set clears at the next edge.
- R13: The two flags are never high together. A wrap in the opposite direction replaces one flag with the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Synchronised track A |
| enc_b | input | 1 | Synchronised track B |
| gate_in | input | 1 | Synchronised gate signal |
| gate_pol | input | 1 | Gate level that blocks counting |
| mode_updown | input | 1 | 0 = quadrature, 1 = up/down pulse mode |
| dir_invert | input | 1 | Reverses the counting direction |
| idx_reset_en | input | 1 | Index-pulse reset source enabled |
| ext_reset_en | input | 1 | External reset source enabled |
| zero_req | input | 1 | Synchronous zero request |
| count | output | CNT_W | Position count |
| ovf_flag | output | 1 | Overflow wrap flag |
| unf_flag | output | 1 | Underflow wrap flag |

## Verification
The assertions assume that A, B and the gate are already synchronised to `clk`. They also assume that a real encoder moves at most one quadrature phase per clock, so any double change is treated as a fault to be ignored and not as a fast move. The stimulus changes every input only at the falling clock edge and holds it for at least one full cycle. It moves the encoder by single phases except in the cases built to test double changes. The flag tests use an 8-bit counter, so that the wrap points and both hysteresis thresholds can be reached by stepping.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;

    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_t;

    typedef enum logic [1:0] {
        FL_CLEAR = 2'b00,
        FL_OVER  = 2'b01,
        FL_UNDER = 2'b10
    } flag_state_t;

endpackage

// File: rtl/qcnt_step_decoder.sv
module qcnt_step_decoder
    import qcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    input  logic mode_updown,
    input  logic dir_invert,
    input  logic blocked,
    output logic step_up,
    output logic step_dn
);

    phase_t     phase_q;
    phase_t     phase_now;
    logic [1:0] prev_bits;
    logic       fwd;
    logic       rev;

    assign phase_now = phase_t'({a, b});
    assign prev_bits = phase_q;

    // state register: always follows the inputs, even while gated
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_00;
        else        phase_q <= phase_now;
    end

    // transition decode
    always_comb begin
        fwd = 1'b0;
        rev = 1'b0;
        if (mode_updown) begin
            fwd = a && !prev_bits[1] && !b;
            rev = a && !prev_bits[1] &&  b;
        end else begin
            unique case (phase_q)
                PH_00: begin fwd = (phase_now == PH_10); rev = (phase_now == PH_01); end
                PH_10: begin fwd = (phase_now == PH_11); rev = (phase_now == PH_00); end
                PH_11: begin fwd = (phase_now == PH_01); rev = (phase_now == PH_10); end
                PH_01: begin fwd = (phase_now == PH_00); rev = (phase_now == PH_11); end
                default: begin fwd = 1'b0; rev = 1'b0; end
            endcase
        end
        step_up = !blocked && (dir_invert ? rev : fwd);
        step_dn = !blocked && (dir_invert ? fwd : rev);
    end

    // R3
    dbl_change_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_updown && (({a, b} ^ prev_bits) == 2'b11)) |-> !(step_up || step_dn));

    // R4
    updown_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_updown && !a) |-> !(step_up || step_dn));

endmodule

// File: rtl/qcnt_accum.sv
module qcnt_accum #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic             zero_req,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_d,
    output logic             wrap_up,
    output logic             wrap_dn
);

    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ONE      = {{(CNT_W-1){1'b0}}, 1'b1};

    always_comb begin
        count_d = count_q;
        wrap_up = 1'b0;
        wrap_dn = 1'b0;
        if (zero_req) begin
            count_d = '0;
        end else if (step_up) begin
            count_d = count_q + ONE;
            wrap_up = (count_q == ALL_ONES);
        end else if (step_dn) begin
            count_d = count_q - ONE;
            wrap_dn = (count_q == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    // R7
    zero_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_req |=> (count_q == '0));

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_req |=> ((count_q == $past(count_q)) ||
                       (count_q == $past(count_q) + ONE) ||
                       (count_q == $past(count_q) - ONE)));

endmodule

// File: rtl/qcnt_wrap_flags.sv
module qcnt_wrap_flags
    import qcnt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             track_en,
    input  logic             wrap_up,
    input  logic             wrap_dn,
    input  logic [CNT_W-1:0] count_d,
    output logic             ovf_flag,
    output logic             unf_flag
);

    localparam logic [CNT_W+1:0] RANGE_W   = {2'b01, {CNT_W{1'b0}}};
    localparam logic [CNT_W+1:0] THIRD_W   = RANGE_W / (CNT_W+2)'(3);
    localparam logic [CNT_W+1:0] TWO_3RD_W = (RANGE_W << 1) / (CNT_W+2)'(3);
    localparam logic [CNT_W-1:0] LOW_MARK  = THIRD_W[CNT_W-1:0];
    localparam logic [CNT_W-1:0] HIGH_MARK = TWO_3RD_W[CNT_W-1:0];

    flag_state_t fl_q;
    flag_state_t fl_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= FL_CLEAR;
        else        fl_q <= fl_d;
    end

    // next state
    always_comb begin
        fl_d = fl_q;
        if (!track_en) begin
            fl_d = FL_CLEAR;
        end else if (wrap_up) begin
            fl_d = FL_OVER;
        end else if (wrap_dn) begin
            fl_d = FL_UNDER;
        end else begin
            unique case (fl_q)
                FL_OVER:  if (count_d > LOW_MARK)  fl_d = FL_CLEAR;
                FL_UNDER: if (count_d < HIGH_MARK) fl_d = FL_CLEAR;
                default:  fl_d = fl_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        ovf_flag = (fl_q == FL_OVER);
        unf_flag = (fl_q == FL_UNDER);
    end

    // R13
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_flag && unf_flag));

    // R12
    track_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !track_en |=> (!ovf_flag && !unf_flag));

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (track_en && wrap_up) |=> ovf_flag);

    // R10
    unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (track_en && wrap_dn) |=> unf_flag);

endmodule

// File: rtl/qenc_position_counter.sv
module qenc_position_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_a,
    input  logic             enc_b,
    input  logic             gate_in,
    input  logic             gate_pol,
    input  logic             mode_updown,
    input  logic             dir_invert,
    input  logic             idx_reset_en,
    input  logic             ext_reset_en,
    input  logic             zero_req,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag,
    output logic             unf_flag
);

    localparam logic [CNT_W+1:0] RANGE_W   = {2'b01, {CNT_W{1'b0}}};
    localparam logic [CNT_W+1:0] THIRD_W   = RANGE_W / (CNT_W+2)'(3);
    localparam logic [CNT_W+1:0] TWO_3RD_W = (RANGE_W << 1) / (CNT_W+2)'(3);
    localparam logic [CNT_W-1:0] LOW_MARK  = THIRD_W[CNT_W-1:0];
    localparam logic [CNT_W-1:0] HIGH_MARK = TWO_3RD_W[CNT_W-1:0];

    logic             blocked;
    logic             track_en;
    logic             step_up;
    logic             step_dn;
    logic             wrap_up;
    logic             wrap_dn;
    logic [CNT_W-1:0] count_d;

    assign blocked  = (gate_in == gate_pol);
    assign track_en = !(idx_reset_en || ext_reset_en);

    qcnt_step_decoder u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .a           (enc_a),
        .b           (enc_b),
        .mode_updown (mode_updown),
        .dir_invert  (dir_invert),
        .blocked     (blocked),
        .step_up     (step_up),
        .step_dn     (step_dn)
    );

    qcnt_accum #(.CNT_W(CNT_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .zero_req (zero_req),
        .count_q  (count),
        .count_d  (count_d),
        .wrap_up  (wrap_up),
        .wrap_dn  (wrap_dn)
    );

    qcnt_wrap_flags #(.CNT_W(CNT_W)) u_flg (
        .clk      (clk),
        .rst_n    (rst_n),
        .track_en (track_en),
        .wrap_up  (wrap_up),
        .wrap_dn  (wrap_dn),
        .count_d  (count_d),
        .ovf_flag (ovf_flag),
        .unf_flag (unf_flag)
    );

    // R6
    gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && !zero_req) |=> $stable(count));

    // R9
    ovf_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |-> (count <= LOW_MARK));

    // R11
    unf_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_flag |-> (count >= HIGH_MARK));

endmodule

// File: tb/qenc_position_counter_tb.sv
module qenc_position_counter_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enc_a = 1'b0, enc_b = 1'b0, gate_in = 1'b0, gate_pol = 1'b1;
    logic         mode_updown = 1'b0, dir_invert = 1'b0;
    logic         idx_reset_en = 1'b0, ext_reset_en = 1'b0, zero_req = 1'b0;
    logic [W-1:0] count;
    logic         ovf_flag, unf_flag;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    qenc_position_counter #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .gate_in(gate_in), .gate_pol(gate_pol), .mode_updown(mode_updown),
        .dir_invert(dir_invert), .idx_reset_en(idx_reset_en),
        .ext_reset_en(ext_reset_en), .zero_req(zero_req),
        .count(count), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    // {a,b} | {gate,mode,inv,zero} | expected count
    localparam logic [13:0] VEC [24] = '{
        {2'b10, 4'b0000, 8'd1}, {2'b11, 4'b0000, 8'd2}, {2'b01, 4'b0000, 8'd3},
        {2'b00, 4'b0000, 8'd4}, {2'b01, 4'b0000, 8'd3}, {2'b11, 4'b0000, 8'd2},
        {2'b00, 4'b0000, 8'd2}, {2'b10, 4'b0000, 8'd3}, {2'b01, 4'b0000, 8'd3},
        {2'b00, 4'b0000, 8'd4}, {2'b10, 4'b1000, 8'd4}, {2'b11, 4'b0000, 8'd5},
        {2'b01, 4'b0010, 8'd4}, {2'b00, 4'b0010, 8'd3}, {2'b10, 4'b0001, 8'd0},
        {2'b11, 4'b0000, 8'd1}, {2'b01, 4'b0100, 8'd1}, {2'b10, 4'b0100, 8'd2},
        {2'b00, 4'b0100, 8'd2}, {2'b01, 4'b0100, 8'd2}, {2'b11, 4'b0100, 8'd1},
        {2'b01, 4'b0100, 8'd1}, {2'b11, 4'b0110, 8'd2}, {2'b01, 4'b0100, 8'd2}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input int i);
        if (i < 10)      return "R2 R3 quad";
        else if (i < 12) return "R6 gate";
        else if (i < 14) return "R5 invert";
        else if (i == 14) return "R7 zero";
        else             return "R4 R5 updown";
    endfunction

    task automatic pulse(input logic down);
        enc_b = down; enc_a = 1'b1;
        @(negedge clk);
        enc_a = 1'b0;
        @(negedge clk);
    endtask

    task automatic zero_it();
        zero_req = 1'b1;
        @(negedge clk);
        zero_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check("R1 count", int'(count), 0);
        check("R1 ovf", int'(ovf_flag), 0);
        check("R1 unf", int'(unf_flag), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < 24; i++) begin
            {enc_a, enc_b, gate_in, mode_updown, dir_invert, zero_req} = VEC[i][13:8];
            @(negedge clk);
            check(tag_of(i), int'(count), int'(VEC[i][7:0]));
        end
        zero_req = 1'b0; dir_invert = 1'b0; gate_in = 1'b0; enc_a = 1'b0;
        @(negedge clk);

        // R6 low-active gate polarity
        gate_pol = 1'b0; gate_in = 1'b0;
        pulse(1'b0);
        check("R6 pol0 blocked", int'(count), 2);
        gate_in = 1'b1;
        pulse(1'b0);
        check("R6 pol0 open", int'(count), 3);
        gate_pol = 1'b1; gate_in = 1'b0;

        // R8 / R9 overflow
        zero_it();
        for (int k = 0; k < 255; k++) pulse(1'b0);
        check("R8 at max", int'(count), 255);
        check("R8 no early ovf", int'(ovf_flag), 0);
        pulse(1'b0);
        check("R8 wrap count", int'(count), 0);
        check("R8 ovf set", int'(ovf_flag), 1);
        for (int k = 0; k < 85; k++) pulse(1'b0);
        check("R9 at third", int'(count), 85);
        check("R9 ovf held", int'(ovf_flag), 1);
        pulse(1'b0);
        check("R9 ovf cleared", int'(ovf_flag), 0);

        // R10 / R11 underflow
        zero_it();
        pulse(1'b1);
        check("R10 wrap count", int'(count), 255);
        check("R10 unf set", int'(unf_flag), 1);
        for (int k = 0; k < 85; k++) pulse(1'b1);
        check("R11 at two thirds", int'(count), 170);
        check("R11 unf held", int'(unf_flag), 1);
        pulse(1'b1);
        check("R11 unf cleared", int'(unf_flag), 0);

        // R13 swap
        zero_it();
        pulse(1'b1);
        check("R13 unf first", int'(unf_flag), 1);
        pulse(1'b0);
        check("R13 ovf after swap", int'(ovf_flag), 1);
        check("R13 unf dropped", int'(unf_flag), 0);

        // R12 tracking disabled
        ext_reset_en = 1'b1;
        @(negedge clk);
        check("R12 flag cleared", int'(ovf_flag), 0);
        pulse(1'b1);
        check("R12 wrap count", int'(count), 255);
        check("R12 no unf", int'(unf_flag), 0);
        ext_reset_en = 1'b0; idx_reset_en = 1'b1;
        pulse(1'b0);
        check("R12 idx no ovf", int'(ovf_flag), 0);
        idx_reset_en = 1'b0;

        finish_run();
    end

endmodule